// File: doc/BRIEF.md
# Synchronous SRAM with Selectable Read Path and Dual-Cycle Deselect

This block is a synthesizable behavioural model of a single-port synchronous SRAM. Chip enable, address, write data, the byte-write enable, the per-lane enables and the global-write input are all captured on the rising clock edge. A static mode input chooses how read data leaves the block. In flow-through mode the word captured on the command edge goes straight to the bus. In pipeline mode it passes through one more rising-edge output register.

Turning the bus off follows the same pipeline as reading data. Any cycle that is not a read (a deselect, a write or an idle cycle) keeps the bus driven for one full cycle. The bus is released only after the second rising edge that follows. Output enable and sleep act asynchronously on the bus. Sleep also blocks new commands, and the array keeps its contents. A bus-drive flag stands in for a real tri-state buffer. Burst address generation sits in a separate block, so every command carries its own address.

Top module: `sync_sram_pipe`

## Requirements
- R1: While and after reset, with no command issued, busDrive is 0 and rdData is 0. The array is cleared to zero.
- R2: With pipeMode high, a read sampled at edge k drives busDrive high and shows the addressed word on rdData after edge k+1.
- R3: With pipeMode low, a read sampled at edge k drives busDrive high and shows the addressed word on rdData after edge k.
- R4: A non-read cycle sampled at edge k keeps the bus driven with the last read word until edge k+1, and releases it after edge k+1, in both modes. A non-read cycle is a deselect, a write or a cycle with chipEn low.
- R5: A byte write (chipEn, byteWrEn and at least one laneEn bit) updates only the enabled lanes. Lane i is wrData bits [8i+7:8i], and laneEn bit i enables it.
- R6: A global write (chipEn and globalWr) updates all lanes, whatever laneEn holds. It takes precedence over a byte write.
- R7: A command with chipEn high, byteWrEn high, no laneEn bit set and globalWr low is a read.
- R8: A read issued on the cycle after a write to the same address returns the newly written word.
- R9: While sleep is high, busDrive is 0 at once, without waiting for a clock edge. Commands sampled during sleep neither read nor write, and the array contents are kept.
- R10: outEn low forces busDrive to 0 at once. It does not change the read pipeline, so raising outEn again shows the data still in flight.
- R11: Whenever busDrive is 0, rdData is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| pipeMode | input | 1 | Static mode: 1 selects the registered read path, 0 selects flow-through |
| chipEn | input | 1 | Chip enable, sampled on the clock edge |
| addr | input | ADDR_W | Word address |
| wrData | input | DATA_W | Write data |
| byteWrEn | input | 1 | Byte-write enable |
| laneEn | input | LANES | Per-lane write enables |
| globalWr | input | 1 | Write all lanes |
| outEn | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power input; blocks commands |
| rdData | output | DATA_W | Read data bus (0 when not driven) |
| busDrive | output | 1 | High while the data bus would be driven |

## Verification
The hardest situation to reach is one where the bus-release pipeline and the data pipeline disagree. Examples are a deselect right after a read, a write squeezed between two reads, or outEn and sleep toggling mid-cycle while a read is still in flight. Each of these must be seen at the exact cycle where the hold ends.

The stimulus drives directed sequences of read, deselect, write and read in both modes. It then runs long random streams with short deselect runs and frequent asynchronous toggles. It changes the asynchronous inputs one time unit after the falling edge and samples the bus again before the next edge. A behavioural model with two-entry history flags predicts every cycle.

// File: rtl/sync_sram_pkg.sv
package sync_sram_pkg;
  typedef struct packed {
    logic rdFire;    // read command accepted this edge
    logic wrFire;    // write command accepted this edge
    logic allLanes;  // write covers every lane
    logic dataLoad;  // move captured read word into output register
    logic busOn;     // bus drive enable (asynchronous terms included)
  } ctrlStrobe_t;
endpackage

// File: rtl/sync_sram_ctrl.sv
module sync_sram_ctrl
  import sync_sram_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pipeMode,
  input  logic        chipEn,
  input  logic        byteWrEn,
  input  logic        laneAny,
  input  logic        globalWr,
  input  logic        outEn,
  input  logic        sleep,
  output ctrlStrobe_t strobe
);
  logic wrCmd, rdCmd;
  logic stage1Rd, stage2Rd;
  logic busOn;

  assign wrCmd = rstN && chipEn && !sleep && (globalWr || (byteWrEn && laneAny));
  assign rdCmd = rstN && chipEn && !sleep && !wrCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Rd <= 1'b0;
      stage2Rd <= 1'b0;
    end else begin
      stage1Rd <= rdCmd;
      stage2Rd <= stage1Rd;
    end
  end

  assign busOn = outEn && !sleep && (pipeMode ? stage2Rd : (stage1Rd || stage2Rd));

  always_comb begin
    strobe.rdFire   = rdCmd;
    strobe.wrFire   = wrCmd;
    strobe.allLanes = globalWr;
    strobe.dataLoad = stage1Rd;
    strobe.busOn    = busOn;
  end

  // R2
  pipe_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && $past(rdCmd, 2) && outEn && !sleep) |-> busOn);

  // R4
  flow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && $past(rdCmd, 2) && !$past(rdCmd) && outEn && !sleep) |-> busOn);

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(rdCmd) && !$past(rdCmd, 2)) |-> !busOn);
endmodule

// File: rtl/sync_sram_dpath.sv
module sync_sram_dpath
  import sync_sram_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  laneEn,
  input  ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] rdData
);
  localparam int LANE_W = DATA_W / LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] wrMask;
  logic [DATA_W-1:0] rdReg, outReg;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign wrMask[g*LANE_W +: LANE_W] = {LANE_W{strobe.allLanes || laneEn[g]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '0;
    end else if (strobe.wrFire) begin
      memArr[addr] <= (memArr[addr] & ~wrMask) | (wrData & wrMask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdReg  <= '0;
      outReg <= '0;
    end else begin
      if (strobe.rdFire)   rdReg  <= memArr[addr];
      if (strobe.dataLoad) outReg <= rdReg;
    end
  end

  assign rdData = strobe.busOn ? (pipeMode ? outReg : rdReg) : '0;

  // R6
  global_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.wrFire && strobe.allLanes) |-> memArr[$past(addr)] == $past(wrData));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R5
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrFire && !strobe.allLanes && !laneEn[g]) |=>
        memArr[$past(addr)][g*LANE_W +: LANE_W] == $past(memArr[addr][g*LANE_W +: LANE_W]));
  end
endmodule

// File: rtl/sync_sram_pipe.sv
module sync_sram_pipe
  import sync_sram_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              chipEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              byteWrEn,
  input  logic [LANES-1:0]  laneEn,
  input  logic              globalWr,
  input  logic              outEn,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdData,
  output logic              busDrive
);
  ctrlStrobe_t strobe;

  sync_sram_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pipeMode (pipeMode),
    .chipEn   (chipEn),
    .byteWrEn (byteWrEn),
    .laneAny  (|laneEn),
    .globalWr (globalWr),
    .outEn    (outEn),
    .sleep    (sleep),
    .strobe   (strobe)
  );

  sync_sram_dpath #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .pipeMode (pipeMode),
    .addr     (addr),
    .wrData   (wrData),
    .laneEn   (laneEn),
    .strobe   (strobe),
    .rdData   (rdData)
  );

  assign busDrive = strobe.busOn;
endmodule

// File: tb/sync_sram_pipe_bench.sv
`timescale 1ns/1ps
module sync_sram_pipe_bench;
  localparam int DW = 32, LN = 4, AW = 4;

  logic clk = 1'b0, rstN = 1'b0, pipeMode = 1'b1;
  logic chipEn = 1'b0, byteWrEn = 1'b0, globalWr = 1'b0, outEn = 1'b1, sleep = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [LN-1:0] laneEn = '0;
  logic [DW-1:0] rdData;
  logic busDrive;

  int total = 0, bad = 0;
  string curReq = "R1";
  bit finished = 0;

  sync_sram_pipe #(.DATA_W(DW), .LANES(LN), .ADDR_W(AW)) u_sync_sram_pipe (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .chipEn(chipEn), .addr(addr),
    .wrData(wrData), .byteWrEn(byteWrEn), .laneEn(laneEn), .globalWr(globalWr),
    .outEn(outEn), .sleep(sleep), .rdData(rdData), .busDrive(busDrive));

  always #2 clk = ~clk;

  // behavioural reference
  logic [DW-1:0] refMem [1<<AW];
  bit h1Rd, h2Rd;
  logic [DW-1:0] flowWord, pipeWord;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (refMem[i]) refMem[i] = '0;
      h1Rd = 0; h2Rd = 0; flowWord = '0; pipeWord = '0;
    end else begin
      bit isWr, isRd;
      isWr = chipEn && !sleep && (globalWr || (byteWrEn && (laneEn != 0)));
      isRd = chipEn && !sleep && !isWr;
      if (h1Rd) pipeWord = flowWord;
      h2Rd = h1Rd;
      h1Rd = isRd;
      if (isRd) flowWord = refMem[addr];
      if (isWr)
        for (int l = 0; l < LN; l++)
          if (globalWr || laneEn[l]) refMem[addr][l*8 +: 8] = wrData[l*8 +: 8];
    end
  end

  function automatic bit expDrive();
    return outEn && !sleep && (pipeMode ? h2Rd : (h1Rd || h2Rd));
  endfunction

  function automatic logic [DW-1:0] expData();
    return expDrive() ? (pipeMode ? pipeWord : flowWord) : '0;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge (R11 checked on every cycle)
  always @(negedge clk) begin
    if (!finished) begin
      chk({curReq, " drive"}, {31'b0, busDrive}, {31'b0, expDrive()});
      chk({curReq, " data/R11"}, rdData, expData());
    end
  end

  task automatic cmd(bit ce, int a, logic [DW-1:0] d, bit bw, logic [LN-1:0] le, bit gw);
    @(negedge clk); #1;
    chipEn = ce; addr = a[AW-1:0]; wrData = d; byteWrEn = bw; laneEn = le; globalWr = gw;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cmd(0, 0, '0, 0, '0, 0);
  endtask

  task automatic doReset(bit mode);
    @(negedge clk); #1;
    rstN = 0; pipeMode = mode; chipEn = 0; outEn = 1; sleep = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rstN = 1;
  endtask

  task automatic directed(bit mode);
    doReset(mode);
    curReq = "R1";
    idle(2);
    curReq = "R6";
    cmd(1, 5, 32'hA5A5_5A5A, 1, 4'b0000, 1);
    cmd(1, 5, '0, 0, '0, 0);                     // R8 read right after write
    curReq = mode ? "R2/R8" : "R3/R8";
    cmd(0, 0, '0, 0, '0, 0);
    curReq = "R4";
    idle(3);
    curReq = "R5";
    cmd(1, 5, 32'h1122_3344, 1, 4'b0101, 0);
    cmd(1, 5, '0, 0, '0, 0);
    curReq = "R4";
    cmd(1, 6, 32'hDEAD_BEEF, 0, 4'b1111, 0);      // byteWrEn low: lanes ignored, read
    cmd(1, 5, '0, 1, 4'b0000, 0);                 // R7
    curReq = "R7";
    idle(3);
    cmd(1, 5, '0, 0, '0, 0);
    curReq = "R10";
    @(negedge clk); #1; outEn = 0;
    #0.5 chk("R10 async off", {31'b0, busDrive}, 32'd0);
    idle(1);
    @(negedge clk); #1; outEn = 1;
    idle(3);
    curReq = "R9";
    cmd(1, 5, '0, 0, '0, 0);
    @(negedge clk); #1; sleep = 1; chipEn = 1; globalWr = 1; wrData = 32'hFFFF_FFFF;
    #0.5 chk("R9 async off", {31'b0, busDrive}, 32'd0);
    idle(2);
    @(negedge clk); #1; sleep = 0;
    cmd(1, 5, '0, 0, '0, 0);
    idle(3);
    chk("R9 retained", {31'b0, refMem[5] == 32'hA522_5A44}, 32'd1);
  endtask

  task automatic randomRun(bit mode, int n);
    doReset(mode);
    curReq = mode ? "R2/R4 random" : "R3/R4 random";
    for (int i = 0; i < n; i++) begin
      int r = $urandom_range(0, 9);
      cmd(r > 2, $urandom_range(0, 3), $urandom, r == 4 || r == 5, LN'($urandom), r == 6);
      if ($urandom_range(0, 7) == 0) begin
        #0.5 outEn = $urandom_range(0, 3) != 0;
        sleep = $urandom_range(0, 5) == 0;
      end
    end
    @(negedge clk); #1; outEn = 1; sleep = 0;
    idle(3);
  endtask

  initial begin
    directed(1);
    directed(0);
    randomRun(1, 600);
    randomRun(0, 600);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule